// File: doc/BRIEF.md
# Fault Snapshot Logger with Dual Commit Policy

This block keeps a bounded history of power-rail fault events for later inspection. For every event offered on its input stream it builds one fixed-format record. The record holds a free-running timestamp, the fault kind (over-voltage, under-voltage, over-current, over-temperature or watchdog), a criticality flag, the rail number, the voltage, current and temperature codes, the power-good level, the sequencing step and the retry count. Records wait in a small staging buffer and leave through a valid/ready write port into a non-volatile log memory. The log memory is addressed as a ring of `LOG_DEPTH` slots.

The staging buffer is drained under two policies. A critical event is written through at once: the drain starts on the cycle after it is accepted. Routine events accumulate and go out as a batch. A batch starts when the buffer fills or when no new event has arrived for `IDLE_CYCLES` cycles. A power-loss input starts the drain at any time. A drain runs until the buffer is empty. Write-protect blocks every commit. Events offered while write-protect is high are accepted, discarded and counted. When the ring is full, the oldest slot is overwritten and a sticky flag records that this has happened.

Back-pressure rules: an event transfers on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is low only while the buffer is full and write-protect is low. A record shown on `nvm_wr_valid` stays unchanged until `nvm_wr_ready` takes it. The one exception is write-protect: when it rises, `nvm_wr_valid` drops at once, and the same record is shown again after write-protect falls.

Top module: `bbl_logger`

## Requirements
- R1: A committed record is, from MSB to LSB: {timestamp, kind[2:0], critical, rail, vcode, icode, tcode, pgood, step, retry}. The timestamp is the number of clock edges counted since reset was released, taken at the edge that accepts the event. The kind codes are 0 over-voltage, 1 under-voltage, 2 over-current, 3 over-temperature and 4 watchdog.
- R2: `ev_ready` is high when `wr_protect` is high or when the staging buffer holds fewer than `BUF_DEPTH` records.
- R3: A critical event accepted with write-protect low makes `nvm_wr_valid` high in the very next cycle.
- R4: Routine events are held back until one of the drain triggers occurs. Accepting the record that fills the buffer starts the drain, and `nvm_wr_valid` rises in the next cycle.
- R5: A routine record with no later event reaches `nvm_wr_valid` exactly `IDLE_CYCLES` cycles after the edge that accepted it.
- R6: A cycle with `pwr_loss` high starts a drain of everything buffered, and the drain continues until the buffer is empty.
- R7: While `wr_protect` is high, `nvm_wr_valid` is low. Events offered during that time are accepted and discarded, and `drop_count` counts them, saturating at all ones.
- R8: Records are committed in acceptance order. A record shown on the write port holds its data and address until `nvm_wr_ready` is high or `wr_protect` rises.
- R9: `nvm_wr_addr` starts at 0 and advances by one per commit, wrapping from `LOG_DEPTH-1` to 0. `log_wrapped` is set by the first wrap and stays set until reset.
- R10: `log_count` counts commits and saturates at `LOG_DEPTH`.
- R11: Once the buffer is empty the drain ends, and a later routine event waits again for a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken |
| ev_critical | input | 1 | Event needs write-through |
| ev_kind | input | 3 | Fault kind code |
| ev_rail | input | RAIL_W | Rail number |
| ev_vcode | input | MEAS_W | Voltage reading |
| ev_icode | input | MEAS_W | Current reading |
| ev_tcode | input | MEAS_W | Temperature reading |
| ev_pgood | input | 1 | Power-good level at the event |
| ev_step | input | STEP_W | Sequencing step |
| ev_retry | input | RETRY_W | Retry count |
| pwr_loss | input | 1 | Supply loss detected, flush now |
| wr_protect | input | 1 | Blocks all commits |
| nvm_wr_valid | output | 1 | Record ready to write |
| nvm_wr_ready | input | 1 | Log memory takes the record |
| nvm_wr_addr | output | AW | Log slot to write |
| nvm_wr_data | output | REC_W | Packed record |
| log_count | output | CW | Commits so far, saturating |
| log_wrapped | output | 1 | Ring has wrapped |
| drop_count | output | DROP_W | Events discarded under write-protect |

## Verification
The bench builds the logger with an 8-slot ring, a 4-record buffer, a 6-cycle idle timeout, a 4-bit drop counter and a 16-bit timestamp. With these sizes the buffer fills after four events, so batch flushes, ring wrap-around, count saturation and drop-counter saturation are all reached within a few hundred cycles. That leaves most of the run for random traffic in which critical events, power loss, write-protect windows and write-port stalls overlap.

// File: rtl/bbl_pkg.sv
package bbl_pkg;

  typedef enum logic [2:0] {
    FK_OV   = 3'd0,
    FK_UV   = 3'd1,
    FK_OC   = 3'd2,
    FK_OT   = 3'd3,
    FK_WDOG = 3'd4
  } fault_kind_e;

  typedef struct packed {
    logic critical;
    logic full;
    logic idle;
    logic power;
  } drain_cause_t;

endpackage

// File: rtl/bbl_tstamp.sv
module bbl_tstamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end
endmodule

// File: rtl/bbl_stage_fifo.sv
module bbl_stage_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    rd_q, wr_q;

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      if (push) wr_q <= advance(wr_q);
      if (pop)  rd_q <= advance(rd_q);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head  = slots[rd_q];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/bbl_commit_policy.sv
module bbl_commit_policy
  import bbl_pkg::*;
#(
  parameter int BUF_DEPTH   = 4,
  parameter int IDLE_CYCLES = 16,
  localparam int CW = $clog2(BUF_DEPTH + 1),
  localparam int IW = $clog2(IDLE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_push,
  input  logic          push_crit,
  input  logic          buf_pop,
  input  logic [CW-1:0] count_now,
  input  logic          pwr_loss,
  output logic          draining
);
  logic [IW-1:0] idle_q;
  logic [CW-1:0] cnt_next;
  logic          idle_hit;
  logic          drain_d;
  drain_cause_t  cause;

  assign cnt_next = count_now + CW'(buf_push) - CW'(buf_pop);
  assign idle_hit = (idle_q == IW'(IDLE_CYCLES - 1)) && (count_now != '0) && !draining;

  always_comb begin
    cause.critical = buf_push & push_crit;
    cause.full     = (cnt_next == CW'(BUF_DEPTH));
    cause.idle     = idle_hit;
    cause.power    = pwr_loss;
    drain_d        = (cnt_next != '0) && (draining || (|cause));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining <= 1'b0;
      idle_q   <= '0;
    end else begin
      draining <= drain_d;
      if (buf_push || cnt_next == '0 || drain_d) idle_q <= '0;
      else                                      idle_q <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/bbl_log_pointer.sv
module bbl_log_pointer #(
  parameter int LOG_DEPTH = 512,
  parameter int DROP_W    = 16,
  localparam int AW = $clog2(LOG_DEPTH),
  localparam int CW = $clog2(LOG_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              drop_evt,
  output logic [AW-1:0]     ptr,
  output logic [CW-1:0]     count,
  output logic              wrapped,
  output logic [DROP_W-1:0] dropped
);
  logic          at_last;
  logic [AW-1:0] ptr_next;

  assign at_last = (ptr == AW'(LOG_DEPTH - 1));

  generate
    if ((1 << AW) == LOG_DEPTH) begin : g_pow2
      assign ptr_next = ptr + 1'b1;
    end else begin : g_mod
      assign ptr_next = at_last ? '0 : ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      count   <= '0;
      wrapped <= 1'b0;
      dropped <= '0;
    end else begin
      if (commit) begin
        ptr <= ptr_next;
        if (at_last) wrapped <= 1'b1;
        if (count != CW'(LOG_DEPTH)) count <= count + 1'b1;
      end
      if (drop_evt && dropped != '1) dropped <= dropped + 1'b1;
    end
  end
endmodule

// File: rtl/bbl_logger.sv
module bbl_logger
  import bbl_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int RAIL_W      = 5,
  parameter int MEAS_W      = 16,
  parameter int STEP_W      = 8,
  parameter int RETRY_W     = 4,
  parameter int LOG_DEPTH   = 512,
  parameter int BUF_DEPTH   = 8,
  parameter int IDLE_CYCLES = 1024,
  parameter int DROP_W      = 16,
  localparam int REC_W = TS_W + 3 + 1 + RAIL_W + 3 * MEAS_W + 1 + STEP_W + RETRY_W,
  localparam int AW    = $clog2(LOG_DEPTH),
  localparam int CW    = $clog2(LOG_DEPTH + 1),
  localparam int BCW   = $clog2(BUF_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic               ev_critical,
  input  logic [2:0]         ev_kind,
  input  logic [RAIL_W-1:0]  ev_rail,
  input  logic [MEAS_W-1:0]  ev_vcode,
  input  logic [MEAS_W-1:0]  ev_icode,
  input  logic [MEAS_W-1:0]  ev_tcode,
  input  logic               ev_pgood,
  input  logic [STEP_W-1:0]  ev_step,
  input  logic [RETRY_W-1:0] ev_retry,
  input  logic               pwr_loss,
  input  logic               wr_protect,
  output logic               nvm_wr_valid,
  input  logic               nvm_wr_ready,
  output logic [AW-1:0]      nvm_wr_addr,
  output logic [REC_W-1:0]   nvm_wr_data,
  output logic [CW-1:0]      log_count,
  output logic               log_wrapped,
  output logic [DROP_W-1:0]  drop_count
);
  logic [TS_W-1:0]  ts_now;
  logic [REC_W-1:0] snap;
  logic [BCW-1:0]   buf_count;
  logic             buf_full, buf_empty;
  logic             accept, buf_push, buf_pop, drop_evt, draining;
  fault_kind_e      kind_tag;

  assign kind_tag = fault_kind_e'(ev_kind);
  assign snap = {ts_now, kind_tag, ev_critical, ev_rail, ev_vcode, ev_icode,
                 ev_tcode, ev_pgood, ev_step, ev_retry};

  assign ev_ready     = wr_protect | ~buf_full;
  assign accept       = ev_valid & ev_ready;
  assign buf_push     = accept & ~wr_protect;
  assign drop_evt     = accept & wr_protect;
  assign nvm_wr_valid = draining & ~buf_empty & ~wr_protect;
  assign buf_pop      = nvm_wr_valid & nvm_wr_ready;

  bbl_tstamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .now(ts_now)
  );

  bbl_stage_fifo #(.WIDTH(REC_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(buf_push), .din(snap), .pop(buf_pop),
    .head(nvm_wr_data), .count(buf_count), .full(buf_full), .empty(buf_empty)
  );

  bbl_commit_policy #(.BUF_DEPTH(BUF_DEPTH), .IDLE_CYCLES(IDLE_CYCLES)) u_pol (
    .clk(clk), .rst_n(rst_n), .buf_push(buf_push), .push_crit(ev_critical),
    .buf_pop(buf_pop), .count_now(buf_count), .pwr_loss(pwr_loss),
    .draining(draining)
  );

  bbl_log_pointer #(.LOG_DEPTH(LOG_DEPTH), .DROP_W(DROP_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .commit(buf_pop), .drop_evt(drop_evt),
    .ptr(nvm_wr_addr), .count(log_count), .wrapped(log_wrapped),
    .dropped(drop_count)
  );
endmodule

// File: rtl/bbl_logger_chk.sv
module bbl_logger_chk #(
  parameter int LOG_DEPTH = 512,
  parameter int REC_W     = 8,
  parameter int AW        = 9,
  parameter int CW        = 10,
  parameter int DROP_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              ev_critical,
  input logic              wr_protect,
  input logic              nvm_wr_valid,
  input logic              nvm_wr_ready,
  input logic [AW-1:0]     nvm_wr_addr,
  input logic [REC_W-1:0]  nvm_wr_data,
  input logic [CW-1:0]     log_count,
  input logic              log_wrapped,
  input logic [DROP_W-1:0] drop_count
);
  a_r7_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> !nvm_wr_valid);

  a_r2_ready_under_protect: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> ev_ready);

  a_r3_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_critical && !wr_protect) |=> (wr_protect || nvm_wr_valid));

  a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_wr_valid && !nvm_wr_ready) |=>
      (wr_protect || (nvm_wr_valid && $stable(nvm_wr_data) && $stable(nvm_wr_addr))));

  a_r9_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    log_wrapped |=> log_wrapped);

  a_r9_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_wr_addr <= AW'(LOG_DEPTH - 1));

  a_r10_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    log_count <= CW'(LOG_DEPTH));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_wr_valid && nvm_wr_ready && log_count != CW'(LOG_DEPTH)) |=>
      (log_count == $past(log_count) + 1'b1));

  a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && wr_protect && drop_count != '1) |=>
      (drop_count == $past(drop_count) + 1'b1));
endmodule

bind bbl_logger bbl_logger_chk #(
  .LOG_DEPTH(LOG_DEPTH), .REC_W(REC_W), .AW(AW), .CW(CW), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_critical(ev_critical), .wr_protect(wr_protect),
  .nvm_wr_valid(nvm_wr_valid), .nvm_wr_ready(nvm_wr_ready),
  .nvm_wr_addr(nvm_wr_addr), .nvm_wr_data(nvm_wr_data),
  .log_count(log_count), .log_wrapped(log_wrapped), .drop_count(drop_count)
);

// File: tb/tb_bbl_logger.sv
`timescale 1ns/1ps
module tb_bbl_logger;
  localparam int TS_W = 16, RAIL_W = 4, MEAS_W = 8, STEP_W = 4, RETRY_W = 3;
  localparam int LOG_DEPTH = 8, BUF_DEPTH = 4, IDLE_CYCLES = 6, DROP_W = 4;
  localparam int REC_W = TS_W + 3 + 1 + RAIL_W + 3 * MEAS_W + 1 + STEP_W + RETRY_W;
  localparam int AW = $clog2(LOG_DEPTH), CW = $clog2(LOG_DEPTH + 1);
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_critical = 1'b0, ev_pgood = 1'b0;
  logic [2:0] ev_kind = '0;
  logic [RAIL_W-1:0] ev_rail = '0;
  logic [MEAS_W-1:0] ev_vcode = '0, ev_icode = '0, ev_tcode = '0;
  logic [STEP_W-1:0] ev_step = '0;
  logic [RETRY_W-1:0] ev_retry = '0;
  logic pwr_loss = 1'b0, wr_protect = 1'b0, nvm_wr_ready = 1'b1;
  logic ev_ready, nvm_wr_valid, log_wrapped;
  logic [AW-1:0] nvm_wr_addr;
  logic [REC_W-1:0] nvm_wr_data;
  logic [CW-1:0] log_count;
  logic [DROP_W-1:0] drop_count;

  always #2.5 clk = ~clk;

  bbl_logger #(
    .TS_W(TS_W), .RAIL_W(RAIL_W), .MEAS_W(MEAS_W), .STEP_W(STEP_W),
    .RETRY_W(RETRY_W), .LOG_DEPTH(LOG_DEPTH), .BUF_DEPTH(BUF_DEPTH),
    .IDLE_CYCLES(IDLE_CYCLES), .DROP_W(DROP_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_critical(ev_critical), .ev_kind(ev_kind), .ev_rail(ev_rail),
    .ev_vcode(ev_vcode), .ev_icode(ev_icode), .ev_tcode(ev_tcode),
    .ev_pgood(ev_pgood), .ev_step(ev_step), .ev_retry(ev_retry),
    .pwr_loss(pwr_loss), .wr_protect(wr_protect), .nvm_wr_valid(nvm_wr_valid),
    .nvm_wr_ready(nvm_wr_ready), .nvm_wr_addr(nvm_wr_addr),
    .nvm_wr_data(nvm_wr_data), .log_count(log_count),
    .log_wrapped(log_wrapped), .drop_count(drop_count)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [REC_W-1:0] pack_rec(input logic [TS_W-1:0] ts);
    return {ts, ev_kind, ev_critical, ev_rail, ev_vcode, ev_icode, ev_tcode,
            ev_pgood, ev_step, ev_retry};
  endfunction

  // behavioural reference model
  logic [REC_W-1:0] mq[$];
  logic [REC_W-1:0] m_mem [LOG_DEPTH];
  logic [REC_W-1:0] d_mem [LOG_DEPTH];
  logic [TS_W-1:0] m_ts;
  int  m_ptr, m_cnt, m_drop, m_idle;
  bit  m_drain, m_wrap;
  bit  x_acc, x_push, x_pop, x_hit, x_trig;
  int  x_n;

  function automatic bit m_ready();
    return wr_protect || (mq.size() < BUF_DEPTH);
  endfunction
  function automatic bit m_valid();
    return m_drain && (mq.size() > 0) && !wr_protect;
  endfunction

  initial begin
    for (int a = 0; a < LOG_DEPTH; a++) begin
      m_mem[a] = '0;
      d_mem[a] = '0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_ts = '0; m_ptr = 0; m_cnt = 0; m_drop = 0; m_idle = 0;
      m_drain = 0; m_wrap = 0;
    end else begin
      x_acc  = ev_valid && m_ready();
      x_push = x_acc && !wr_protect;
      x_pop  = m_valid() && nvm_wr_ready;
      x_hit  = (m_idle == IDLE_CYCLES - 1) && (mq.size() > 0) && !m_drain;
      if (x_pop) begin
        m_mem[m_ptr] = mq.pop_front();
        if (m_ptr == LOG_DEPTH - 1) begin m_ptr = 0; m_wrap = 1; end
        else m_ptr++;
        if (m_cnt < LOG_DEPTH) m_cnt++;
      end
      if (x_acc && wr_protect && m_drop < (1 << DROP_W) - 1) m_drop++;
      if (x_push) mq.push_back(pack_rec(m_ts));
      x_n    = mq.size();
      x_trig = (x_push && ev_critical) || (x_n == BUF_DEPTH) || x_hit || pwr_loss;
      m_drain = (x_n != 0) && (m_drain || x_trig);
      m_idle  = (x_push || x_n == 0 || m_drain) ? 0 : m_idle + 1;
      m_ts    = m_ts + 1'b1;
      if (nvm_wr_valid && nvm_wr_ready) d_mem[nvm_wr_addr] = nvm_wr_data;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ev_ready === m_ready(), "R2 ev_ready", 64'(ev_ready), 64'(m_ready()));
      chk(nvm_wr_valid === m_valid(), "R8 nvm_wr_valid", 64'(nvm_wr_valid), 64'(m_valid()));
      if (m_valid())
        chk(nvm_wr_data === mq[0], "R1 record content", 64'(nvm_wr_data), 64'(mq[0]));
      chk(nvm_wr_addr === AW'(m_ptr), "R9 address", 64'(nvm_wr_addr), 64'(m_ptr));
      chk(log_wrapped === m_wrap, "R9 wrap flag", 64'(log_wrapped), 64'(m_wrap));
      chk(log_count === CW'(m_cnt), "R10 entry count", 64'(log_count), 64'(m_cnt));
      chk(drop_count === DROP_W'(m_drop), "R7 drop count", 64'(drop_count), 64'(m_drop));
    end
  end

  task automatic fields();
    ev_kind  = 3'($urandom % 5);
    ev_rail  = RAIL_W'($urandom);
    ev_vcode = MEAS_W'($urandom);
    ev_icode = MEAS_W'($urandom);
    ev_tcode = MEAS_W'($urandom);
    ev_pgood = 1'($urandom);
    ev_step  = STEP_W'($urandom);
    ev_retry = RETRY_W'($urandom);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    report();
  end

  logic [TS_W-1:0] exp_ts;
  logic [REC_W-1:0] exp_rec;

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(ev_ready === 1'b1, "R2 reset ready", 64'(ev_ready), 64'd1);
    chk(nvm_wr_valid === 1'b0, "R8 reset valid", 64'(nvm_wr_valid), 64'd0);
    chk(log_count === '0, "R10 reset count", 64'(log_count), 64'd0);
    chk(log_wrapped === 1'b0, "R9 reset wrap", 64'(log_wrapped), 64'd0);
    chk(drop_count === '0, "R7 reset drops", 64'(drop_count), 64'd0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: single routine event, idle timeout
    #1 fields(); ev_valid = 1; ev_critical = 0; exp_ts = m_ts;
    exp_rec = pack_rec(exp_ts);
    @(negedge clk); #1 ev_valid = 0;
    for (int k = 1; k <= IDLE_CYCLES; k++) begin
      @(negedge clk);
      chk(nvm_wr_valid === (k == IDLE_CYCLES), "R5 idle timeout", 64'(nvm_wr_valid), 64'(k == IDLE_CYCLES));
    end
    chk(nvm_wr_data === exp_rec, "R1 packed snapshot", 64'(nvm_wr_data), 64'(exp_rec));
    chk(nvm_wr_addr === '0, "R9 first slot", 64'(nvm_wr_addr), 64'd0);
    repeat (2) @(negedge clk);

    // R3: critical write-through
    #1 fields(); ev_valid = 1; ev_critical = 1;
    @(negedge clk);
    chk(nvm_wr_valid === 1'b1, "R3 write-through", 64'(nvm_wr_valid), 64'd1);
    #1 ev_valid = 0; ev_critical = 0;
    @(negedge clk);
    chk(nvm_wr_valid === 1'b0, "R3 single commit", 64'(nvm_wr_valid), 64'd0);

    // R4: fill triggers batch, R11 drain ends when empty
    #1 fields(); ev_valid = 1;
    @(negedge clk); #1 fields();
    @(negedge clk); #1 fields();
    @(negedge clk);
    chk(nvm_wr_valid === 1'b0, "R4 held before full", 64'(nvm_wr_valid), 64'd0);
    #1 fields();
    @(negedge clk);
    chk(nvm_wr_valid === 1'b1, "R4 batch on full", 64'(nvm_wr_valid), 64'd1);
    #1 ev_valid = 0;
    repeat (4) @(negedge clk);
    chk(nvm_wr_valid === 1'b0, "R11 drain finished", 64'(nvm_wr_valid), 64'd0);
    #1 fields(); ev_valid = 1;
    @(negedge clk); #1 ev_valid = 0;
    @(negedge clk);
    chk(nvm_wr_valid === 1'b0, "R11 routine waits again", 64'(nvm_wr_valid), 64'd0);
    repeat (IDLE_CYCLES + 2) @(negedge clk);

    // R6: power loss flushes the buffer
    #1 fields(); ev_valid = 1;
    @(negedge clk); #1 fields();
    @(negedge clk);
    chk(nvm_wr_valid === 1'b0, "R6 buffered before loss", 64'(nvm_wr_valid), 64'd0);
    #1 ev_valid = 0; pwr_loss = 1;
    @(negedge clk);
    chk(nvm_wr_valid === 1'b1, "R6 flush started", 64'(nvm_wr_valid), 64'd1);
    #1 pwr_loss = 0;
    repeat (2) @(negedge clk);
    chk(nvm_wr_valid === 1'b0, "R6 flush complete", 64'(nvm_wr_valid), 64'd0);

    // R7: write-protect blocks commits, counts drops
    #1 fields(); ev_valid = 1;
    @(negedge clk); #1 ev_valid = 0; wr_protect = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(nvm_wr_valid === 1'b0, "R7 commit blocked", 64'(nvm_wr_valid), 64'd0);
      #1 ev_valid = (k % 5 == 1); fields();
    end
    @(negedge clk);
    chk(drop_count === DROP_W'(4), "R7 drops counted", 64'(drop_count), 64'd4);
    #1 ev_valid = 0; wr_protect = 0;
    #1 chk(nvm_wr_valid === 1'b1, "R8 record shown after protect", 64'(nvm_wr_valid), 64'd1);
    repeat (3) @(negedge clk);
    chk(log_wrapped === 1'b1, "R9 ring wrapped", 64'(log_wrapped), 64'd1);
    chk(log_count === CW'(LOG_DEPTH), "R10 count saturated", 64'(log_count), 64'(LOG_DEPTH));

    // mixed random traffic with stalls
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk); #1
      fields();
      ev_valid     = ($urandom % 3 == 0);
      ev_critical  = ($urandom % 8 == 0);
      pwr_loss     = ($urandom % 50 == 0);
      nvm_wr_ready = ($urandom % 4 != 0);
      if ($urandom % 40 == 0) wr_protect = ~wr_protect;
    end
    @(negedge clk); #1 ev_valid = 0; wr_protect = 0; nvm_wr_ready = 1; pwr_loss = 1;
    @(negedge clk); #1 pwr_loss = 0;
    repeat (BUF_DEPTH + 4) @(negedge clk);

    // R7: drop counter saturation
    #1 wr_protect = 1; ev_valid = 1;
    repeat (20) @(negedge clk);
    #1 ev_valid = 0;
    @(negedge clk);
    chk(drop_count === '1, "R7 drop saturation", 64'(drop_count), 64'((1 << DROP_W) - 1));
    #1 wr_protect = 0;
    repeat (3) @(negedge clk);

    for (int a = 0; a < LOG_DEPTH; a++)
      chk(d_mem[a] === m_mem[a], "R8 log content in order", 64'(d_mem[a]), 64'(m_mem[a]));
    report();
  end
endmodule